// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block sits next to a UART transmitter and receiver and handles in-band software flow control. Every received character is compared against programmed stop (Xoff) and resume (Xon) characters. A matched stop character halts the transmitter's data traffic at the next character boundary and raises an interrupt flag. A matched resume character lifts the halt. Matched control characters are removed from the receive stream. Everything else passes through unchanged.

In the other direction, the receive side raises `rx_stop_req` when it wants the far end to pause. The controller then asks the transmitter to insert the stop character(s), and asks it to insert the resume character(s) once the request drops. If transmit flow control is switched off after a stop character has gone out, the resume character(s) are inserted automatically. Inserted characters take precedence over queued data, but they never cut into a character that is already on the line.

The block supports `NSET` character sets (two by default). The mode field holds one bit per set for each direction. Software flow control and hardware flow control are never enabled together, so this block does not handle any interaction with modem-line flow control.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: `flow_en[3:2]` is the receive mask and `flow_en[1:0]` is the transmit mask. Bit k of a mask selects character set k, where set k is `xon_chars[8k+7:8k]` and `xoff_chars[8k+7:8k]`. In the receive mask, 00 means off, 01 means set 0, 10 means set 1, and 11 means either set. In the transmit mask, 00 means off, 01 means set 0, 10 means set 1, and 11 means set 0 followed by set 1.
- R2: A strobed character that equals an Xoff of an enabled receive set halts data. With `tx_busy` low, `tx_hold` rises after the second clock edge following the strobe.
- R3: The halt component of `tx_hold` changes only on clock edges where `tx_busy` is sampled low. A character in progress is always finished first.
- R4: A strobed character that equals an enabled Xon clears the halt at the next boundary. A receive mask of 00 also clears the halt. If one character matches both Xon and Xoff, Xoff wins.
- R5: An Xoff match sets `int_flag` on the next edge. The flag does not hold transmission by itself, so it stays set after an Xon has removed the halt.
- R6: A cycle with `iir_rd` high clears `int_flag` on the next edge. If an Xoff match arrives in the same cycle, the set wins.
- R7: In the same cycle as the strobe, `rx_pass_valid` is `rx_valid` with enabled matches removed, and `rx_pass_data` equals `rx_data`.
- R8: `rx_stop_req` high, a non-zero transmit mask and no stop outstanding together queue the stop characters of the masked sets, lowest set first. `ins_req` is high while the queue is non-empty and `tx_busy` is low. `ins_data` shows the head of the queue, and each `ins_ack` pops one character.
- R9: Once the queue has drained after a stop, `rx_stop_req` low queues the Xon characters of the sets that the stop used.
- R10: Setting the transmit mask to 00 while a stop is outstanding queues the resume characters automatically.
- R11: `tx_hold` is high whenever an inserted character is queued, so inserts take priority over data.
- R12: Reset (synchronous, `rst_n` low) leaves transmission allowed, no stop outstanding, no insert queued and `int_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_en | input | 2*NSET | Receive mask (upper half) and transmit mask (lower half) |
| xon_chars | input | NSET*W | Resume character for each set |
| xoff_chars | input | NSET*W | Stop character for each set |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | W | Received character |
| rx_pass_valid | output | 1 | Strobe forwarded to the receive data path |
| rx_pass_data | output | W | Forwarded character |
| rx_stop_req | input | 1 | Receive side asks the far end to pause |
| tx_busy | input | 1 | Transmitter is inside a character |
| tx_hold | output | 1 | Transmitter must not start a data character |
| ins_req | output | 1 | Request to send an inserted control character |
| ins_data | output | W | Character to insert |
| ins_ack | input | 1 | Transmitter has taken the inserted character |
| iir_rd | input | 1 | Host read of the interrupt identification |
| int_flag | output | 1 | Special-character interrupt flag |

## Verification
The main sweep covers all sixteen mode values with each of the four control characters and one ordinary character. This separates a match in an enabled set from the same character in a disabled set, and pass-through from consumption. Directed runs hold `tx_busy` high across a stop, which distinguishes a boundary-aligned halt from an immediate one. They also drop the halt while the flag stays up, to show that the interrupt is independent of the halt, and they coincide a host read with a stop to check that the set takes precedence. Insert sequences for single-set and dual-set transmit masks, and for disabling the mask while stopped, check the order of inserted characters and the automatic resume.

// File: rtl/xfc_pkg.sv
// Shared types for the software flow controller.
package xfc_pkg;

    // Result of comparing one received character with the control set.
    typedef struct packed {
        logic on_hit;   // matched an enabled resume character
        logic off_hit;  // matched an enabled stop character
    } xfc_hit_t;

endpackage

// File: rtl/xfc_rx_match.sv
// Compares each strobed received character with the resume and stop
// characters of the sets enabled in the receive mask, and removes matched
// characters from the forwarded stream.
// Assumes: rx_data is valid only when rx_valid is high.
module xfc_rx_match #(
    parameter int W    = 8,
    parameter int NSET = 2
) (
    input  logic [NSET-1:0]   rx_mask,
    input  logic [NSET*W-1:0] xon_chars,
    input  logic [NSET*W-1:0] xoff_chars,
    input  logic              rx_valid,
    input  logic [W-1:0]      rx_data,
    output xfc_pkg::xfc_hit_t hit,
    output logic              pass_valid,
    output logic [W-1:0]      pass_data
);
    logic [NSET-1:0] on_k;
    logic [NSET-1:0] off_k;

    // One comparator pair for each character set.
    for (genvar k = 0; k < NSET; k++) begin : g_set
        assign on_k[k]  = rx_mask[k] && (rx_data == xon_chars[k*W +: W]);
        assign off_k[k] = rx_mask[k] && (rx_data == xoff_chars[k*W +: W]);
    end

    // Combine the per-set results and gate the forwarded strobe.
    always_comb begin
        hit.on_hit  = rx_valid && (|on_k);
        hit.off_hit = rx_valid && (|off_k);
        pass_valid  = rx_valid && !(|on_k) && !(|off_k);
        pass_data   = rx_data;
    end
endmodule

// File: rtl/xfc_halt_gate.sv
// Keeps the remote-requested halt and passes it to the transmitter only at
// character boundaries (cycles where tx_busy is low).
// Assumes: a stop match takes precedence over a resume match in the same cycle.
module xfc_halt_gate (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enabled,
    input  xfc_pkg::xfc_hit_t hit,
    input  logic              tx_busy,
    output logic              hold_core
);
    logic halt_q;

    // Track the halt requested by the far end.
    always_ff @(posedge clk) begin
        if (!rst_n)              halt_q <= 1'b0;
        else if (!rx_enabled)    halt_q <= 1'b0;
        else if (hit.off_hit)    halt_q <= 1'b1;
        else if (hit.on_hit)     halt_q <= 1'b0;
    end

    // Copy the halt to the transmitter only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_core <= 1'b0;
        else if (!tx_busy) hold_core <= halt_q;
    end
endmodule

// File: rtl/xfc_irq.sv
// Special-character interrupt flag: set by a stop match, cleared by a host
// read of the interrupt identification. It has no effect on transmission.
module xfc_irq (
    input  logic              clk,
    input  logic              rst_n,
    input  xfc_pkg::xfc_hit_t hit,
    input  logic              iir_rd,
    output logic              int_flag
);
    // A set in the same cycle as a read takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           int_flag <= 1'b0;
        else if (hit.off_hit) int_flag <= 1'b1;
        else if (iir_rd)      int_flag <= 1'b0;
    end
endmodule

// File: rtl/xfc_ins_seq.sv
// Decides when to send stop and resume characters, and holds them in a
// small queue that the transmitter drains at character boundaries.
// Assumes: ins_ack pulses for one cycle only while ins_req is high.
module xfc_ins_seq #(
    parameter int W    = 8,
    parameter int NSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSET-1:0]   tx_mask,
    input  logic [NSET*W-1:0] xon_chars,
    input  logic [NSET*W-1:0] xoff_chars,
    input  logic              stop_req,
    input  logic              tx_busy,
    input  logic              ins_ack,
    output logic              ins_req,
    output logic [W-1:0]      ins_data,
    output logic              ins_pend,
    output logic              xoff_out
);
    localparam int CW = $clog2(NSET + 1);

    logic [W-1:0]    q [NSET];
    logic [CW-1:0]   q_cnt;
    logic [NSET-1:0] sent_mask;
    logic            empty;
    logic            want_off;
    logic            want_on;
    logic [NSET-1:0] ld_mask;
    logic [NSET*W-1:0] ld_chars;
    logic [W-1:0]    ld_q [NSET];
    logic [CW-1:0]   ld_cnt;

    assign empty    = (q_cnt == '0);
    assign ins_pend = !empty;
    assign ins_req  = !empty && !tx_busy;
    assign ins_data = q[0];

    // Decide whether a stop or a resume must be queued this cycle.
    always_comb begin
        want_off = empty && !xoff_out && (|tx_mask) && stop_req;
        want_on  = empty && xoff_out && (!stop_req || (tx_mask == '0));
        ld_mask  = want_off ? tx_mask : sent_mask;
        ld_chars = want_off ? xoff_chars : xon_chars;
    end

    // Pack the characters of the selected sets, lowest set first.
    always_comb begin
        ld_cnt = '0;
        for (int i = 0; i < NSET; i++) ld_q[i] = '0;
        for (int k = 0; k < NSET; k++) begin
            if (ld_mask[k]) begin
                ld_q[ld_cnt] = ld_chars[k*W +: W];
                ld_cnt       = ld_cnt + 1'b1;
            end
        end
    end

    // Queue storage: load when empty, shift on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cnt <= '0;
            for (int i = 0; i < NSET; i++) q[i] <= '0;
        end else if (want_off || want_on) begin
            q_cnt <= ld_cnt;
            for (int i = 0; i < NSET; i++) q[i] <= ld_q[i];
        end else if (ins_ack && !empty) begin
            q_cnt <= q_cnt - 1'b1;
            for (int i = 0; i < NSET - 1; i++) q[i] <= q[i+1];
            q[NSET-1] <= '0;
        end
    end

    // Remember that a stop was sent, and which sets it used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_out  <= 1'b0;
            sent_mask <= '0;
        end else if (want_off) begin
            xoff_out  <= 1'b1;
            sent_mask <= tx_mask;
        end else if (want_on) begin
            xoff_out  <= 1'b0;
        end
    end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
// Top of the in-band software flow controller. It connects the receive
// matcher, the boundary-aligned halt gate, the interrupt flag and the
// insert sequencer. A queued insert also holds data so that it goes first.
// Assumes: hardware flow control is disabled while this block is in use.
module xonxoff_flow_ctrl #(
    parameter int W    = 8,
    parameter int NSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*NSET-1:0] flow_en,
    input  logic [NSET*W-1:0] xon_chars,
    input  logic [NSET*W-1:0] xoff_chars,
    input  logic              rx_valid,
    input  logic [W-1:0]      rx_data,
    output logic              rx_pass_valid,
    output logic [W-1:0]      rx_pass_data,
    input  logic              rx_stop_req,
    input  logic              tx_busy,
    output logic              tx_hold,
    output logic              ins_req,
    output logic [W-1:0]      ins_data,
    input  logic              ins_ack,
    input  logic              iir_rd,
    output logic              int_flag
);
    logic [NSET-1:0]   rx_mask;
    logic [NSET-1:0]   tx_mask;
    xfc_pkg::xfc_hit_t hit;
    logic              hold_core;
    logic              ins_pend;
    logic              xoff_out;

    assign rx_mask = flow_en[2*NSET-1:NSET];
    assign tx_mask = flow_en[NSET-1:0];

    xfc_rx_match #(.W(W), .NSET(NSET)) u_match (
        .rx_mask    (rx_mask),
        .xon_chars  (xon_chars),
        .xoff_chars (xoff_chars),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .hit        (hit),
        .pass_valid (rx_pass_valid),
        .pass_data  (rx_pass_data)
    );

    xfc_halt_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enabled (|rx_mask),
        .hit        (hit),
        .tx_busy    (tx_busy),
        .hold_core  (hold_core)
    );

    xfc_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .iir_rd   (iir_rd),
        .int_flag (int_flag)
    );

    xfc_ins_seq #(.W(W), .NSET(NSET)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_mask    (tx_mask),
        .xon_chars  (xon_chars),
        .xoff_chars (xoff_chars),
        .stop_req   (rx_stop_req),
        .tx_busy    (tx_busy),
        .ins_ack    (ins_ack),
        .ins_req    (ins_req),
        .ins_data   (ins_data),
        .ins_pend   (ins_pend),
        .xoff_out   (xoff_out)
    );

    // Data is held by a remote halt or by any pending insert.
    assign tx_hold = hold_core | ins_pend;
endmodule

// File: rtl/xfc_checker.sv
// Temporal checks for the flow controller, attached to the top via bind.
module xfc_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_pass_valid,
    input logic on_hit,
    input logic off_hit,
    input logic tx_busy,
    input logic hold_core,
    input logic tx_hold,
    input logic ins_req,
    input logic iir_rd,
    input logic int_flag
);
    // R5: a stop match raises the flag on the next edge.
    a_r5_flag_on_xoff: assert property (@(posedge clk) disable iff (!rst_n)
        off_hit |=> int_flag);

    // R6: a host read without a coinciding match clears the flag.
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !off_hit) |=> !int_flag);

    // R3: the halt never moves while a character is on the line.
    a_r3_hold_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(hold_core));

    // R11: a requested insert always holds data back.
    a_r11_ins_priority: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req |-> tx_hold);

    // R7: matched control characters are never forwarded.
    a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (on_hit || off_hit)) |-> !rx_pass_valid);

    // R8: no insert request is made during a character.
    a_r8_no_ins_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !ins_req);
endmodule

bind xonxoff_flow_ctrl xfc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_pass_valid (rx_pass_valid),
    .on_hit        (hit.on_hit),
    .off_hit       (hit.off_hit),
    .tx_busy       (tx_busy),
    .hold_core     (hold_core),
    .tx_hold       (tx_hold),
    .ins_req       (ins_req),
    .iir_rd        (iir_rd),
    .int_flag      (int_flag)
);

// File: tb/tb_xonxoff_flow_ctrl.sv
module tb_xonxoff_flow_ctrl;
    localparam int W = 8;
    localparam int NSET = 2;
    localparam logic [7:0] ON0 = 8'h11, OFF0 = 8'h13, ON1 = 8'h91, OFF1 = 8'h93, PLAIN = 8'h41;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] flow_en = '0;
    logic [15:0] xon_chars  = {ON1, ON0};
    logic [15:0] xoff_chars = {OFF1, OFF0};
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_pass_valid;
    logic [7:0] rx_pass_data;
    logic rx_stop_req = 1'b0;
    logic tx_busy = 1'b0;
    logic tx_hold;
    logic ins_req;
    logic [7:0] ins_data;
    logic ins_ack = 1'b0;
    logic iir_rd = 1'b0;
    logic int_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xonxoff_flow_ctrl #(.W(W), .NSET(NSET)) dut (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en),
        .xon_chars(xon_chars), .xoff_chars(xoff_chars),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_pass_valid(rx_pass_valid), .rx_pass_data(rx_pass_data),
        .rx_stop_req(rx_stop_req), .tx_busy(tx_busy), .tx_hold(tx_hold),
        .ins_req(ins_req), .ins_data(ins_data), .ins_ack(ins_ack),
        .iir_rd(iir_rd), .int_flag(int_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic rx_char(input logic [7:0] c);
        rx_valid = 1'b1;
        rx_data  = c;
        #1;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        // R12: reset state
        chk("R12 tx_hold", tx_hold, 0);
        chk("R12 ins_req", ins_req, 0);
        chk("R12 int_flag", int_flag, 0);

        // R1 R2 R4 R5 R6 R7: sweep all modes against every character class
        for (int en = 0; en < 16; en++) begin
            for (int c = 0; c < 5; c++) begin
                logic [7:0] ch;
                logic [1:0] rxm;
                logic eoff, eon;
                ch  = (c == 0) ? ON0 : (c == 1) ? OFF0 : (c == 2) ? ON1 : (c == 3) ? OFF1 : PLAIN;
                rxm = en[3:2];
                eoff = (c == 1 && rxm[0]) || (c == 3 && rxm[1]);
                eon  = (c == 0 && rxm[0]) || (c == 2 && rxm[1]);
                do_reset();
                flow_en = en[3:0];
                rx_char(ch);
                chk("R7 pass_valid", rx_pass_valid, !(eoff || eon));
                chk("R7 pass_data", rx_pass_data, ch);
                step();
                rx_valid = 1'b0;
                chk("R5 flag set", int_flag, eoff);
                step();
                chk("R2 halt", tx_hold, eoff);
                iir_rd = 1'b1;
                step();
                iir_rd = 1'b0;
                chk("R6 flag cleared", int_flag, 0);
            end
        end

        // R3: halt waits for the character boundary
        do_reset();
        flow_en = 4'b0100;
        tx_busy = 1'b1;
        rx_char(OFF0);
        step();
        rx_valid = 1'b0;
        step(); step(); step();
        chk("R3 hold during busy", tx_hold, 0);
        tx_busy = 1'b0;
        step();
        chk("R3 hold after boundary", tx_hold, 1);

        // R4 R5: resume clears the halt, flag stays set
        rx_char(ON0);
        step();
        rx_valid = 1'b0;
        step();
        chk("R4 resume", tx_hold, 0);
        chk("R5 flag independent", int_flag, 1);
        // R4: disabling the receive mask clears a halt
        rx_char(OFF0);
        step();
        rx_valid = 1'b0;
        step();
        chk("R4 halted again", tx_hold, 1);
        flow_en = 4'b0000;
        step(); step();
        chk("R4 rx off clears halt", tx_hold, 0);

        // R6: set wins over a coinciding read
        flow_en = 4'b0100;
        iir_rd = 1'b1;
        rx_char(OFF0);
        step();
        rx_valid = 1'b0;
        iir_rd = 1'b0;
        chk("R6 set wins", int_flag, 1);

        // R8 R9 R11: dual-set insert sequence
        do_reset();
        flow_en = 4'b0011;
        rx_stop_req = 1'b1;
        step();
        chk("R8 ins_req", ins_req, 1);
        chk("R8 first stop", ins_data, OFF0);
        chk("R11 hold while queued", tx_hold, 1);
        tx_busy = 1'b1;
        #1;
        chk("R8 no req when busy", ins_req, 0);
        tx_busy = 1'b0;
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R8 second stop", ins_data, OFF1);
        chk("R8 still req", ins_req, 1);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R8 drained", ins_req, 0);
        chk("R11 hold released", tx_hold, 0);
        step();
        chk("R8 no repeat", ins_req, 0);
        rx_stop_req = 1'b0;
        step();
        chk("R9 first resume", ins_data, ON0);
        ins_ack = 1'b1;
        step();
        chk("R9 second resume", ins_data, ON1);
        step();
        ins_ack = 1'b0;
        chk("R9 drained", ins_req, 0);

        // R9: resume uses the set of the stop even if the mask changed
        do_reset();
        flow_en = 4'b0010;
        rx_stop_req = 1'b1;
        step();
        chk("R1 set1 stop", ins_data, OFF1);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        flow_en = 4'b0001;
        rx_stop_req = 1'b0;
        step();
        chk("R9 resume of sent set", ins_data, ON1);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R9 done", ins_req, 0);

        // R10: disabling transmit flow control after a stop sends resume
        do_reset();
        flow_en = 4'b0001;
        rx_stop_req = 1'b1;
        step();
        chk("R10 stop sent", ins_data, OFF0);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        flow_en = 4'b0000;
        step();
        chk("R10 auto resume req", ins_req, 1);
        chk("R10 auto resume data", ins_data, ON0);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        step();
        chk("R10 single resume", ins_req, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule